// File: doc/BRIEF.md
# Two-Wire Slave Paged Byte Memory

This block is a serial slave on a two-wire bus (clock line and open-drain data line) that gives a bus master access to a 2048-byte register array, seen as eight 256-byte pages. The master selects a page inside the slave address byte itself. The low eight address bits come from a word-address byte that follows the slave address in a write. Both bus lines are oversampled by the fast system clock through two-flop synchronizers, and every protocol event is detected on the synchronized levels.

In a write, the master sends the slave address, one word-address byte, and any number of data bytes. Each data byte is stored and acknowledged, and the 11-bit internal address then steps by one. In a read, the slave shifts out bytes from the internal address for as long as the master acknowledges them. A start condition re-arms address matching at any point. A stop condition abandons whatever is pending. A slave address with the wrong device type leaves the block silent until the next start. The data line is never driven high: the block only asserts a pull-low enable.

Top module: `twi_paged_mem`

## Requirements
- R1: A start condition (data falling while clock is high) aborts any operation, including a partly shifted byte that is then not stored, and the next byte is taken as a slave address.
- R2: A stop condition (data rising while clock is high) releases the data line, abandons a partly received byte, and the block acknowledges nothing until the next start. After reset the data line is released.
- R3: A slave address whose bits 7..4 differ from 1010b gets no acknowledge, and every byte after it is ignored (not acknowledged, not stored) until the next start.
- R4: After each matching slave address, word-address byte and write data byte, the block pulls the data line low for the ninth clock. The pull-low enable changes only while the clock is low.
- R5: Slave address bits 3..1 set the page (address bits 10..8), and bit 0 sets the direction (1 = read). The byte after a write address sets address bits 7..0.
- R6: Each acknowledged write data byte is stored at the internal address, and the address then increments as an 11-bit value. Writes cross page boundaries, and 0x7FF wraps to 0x000.
- R7: A read returns bytes MSB first, starting at the address formed by the page bits and the current low address byte. It advances by one (across pages, with wrap) after each byte, for as long as the master acknowledges.
- R8: A master NACK (data high on the ninth clock of a read byte) ends the read, and the data line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired-AND of all drivers) |
| sdaDriveLow | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
The hardest case to reach from the ports is a byte that is cut off partway by a start or stop condition. The block must neither store it nor acknowledge it, and must still accept a fresh slave address straight away. The bench's master model sends only a few bits of a data byte and then issues a repeated start or a stop. Target locations are pre-written with known values, so reading them back shows that nothing was stored. The 0x7FF-to-0x000 wrap is reached by a write at page 7, word 0xFF that spills into page 0, and by a sequential read that runs across that same boundary.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic setPage;   // load page bits from the slave address
    logic setWord;   // load low address byte
    logic writeMem;  // store received byte at current address
    logic incAddr;   // step the internal address
    logic loadTx;    // fetch byte for transmission
    logic shiftTx;   // advance transmit shifter
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_MWAIT
  } ctrlState_t;

  typedef enum logic [1:0] {
    K_DEV, K_WORD, K_DATA
  } rxKind_t;

endpackage

// File: rtl/twi_mem_dp.sv
module twi_mem_dp
  import twi_mem_pkg::*;
#(
  parameter int PAGE_BITS   = 3,
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  dpStrobe_t strobe,
  output logic      startEv,
  output logic      stopEv,
  output logic      sclRise,
  output logic      sclFall,
  output logic      sdaSync,
  output logic [3:0] devType,
  output logic      rwBit,
  output logic      txBit
);
  localparam int ADDR_BITS = PAGE_BITS + WORD_BITS;
  localparam int DEPTH     = 1 << ADDR_BITS;

  // index 1 = clock line, index 0 = data line
  logic [1:0] rawLines;
  logic [1:0] syncLines;
  logic [1:0] prevLines;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gen_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[SYNC_STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLines <= 2'b11;
    else        prevLines <= syncLines;
  end

  logic sclSync;
  assign sclSync = syncLines[1];
  assign sdaSync = syncLines[0];
  assign sclRise = sclSync & ~prevLines[1];
  assign sclFall = ~sclSync & prevLines[1];
  assign startEv = sclSync & prevLines[1] & prevLines[0] & ~sdaSync;
  assign stopEv  = sclSync & prevLines[1] & ~prevLines[0] & sdaSync;

  logic [BYTE_W-1:0]    rxByte;
  logic [BYTE_W-1:0]    txReg;
  logic [ADDR_BITS-1:0] addr;
  logic [BYTE_W-1:0]    mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte <= '0;
      txReg  <= '0;
      addr   <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaSync};
      if (strobe.setPage) addr[ADDR_BITS-1:WORD_BITS] <= rxByte[PAGE_BITS:1];
      if (strobe.setWord) addr[WORD_BITS-1:0] <= rxByte[WORD_BITS-1:0];
      if (strobe.incAddr) addr <= addr + ADDR_BITS'(1);
      if (strobe.loadTx)       txReg <= mem[addr];
      else if (strobe.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeMem) mem[addr] <= rxByte;
  end

  assign devType = rxByte[BYTE_W-1:BYTE_W-4];
  assign rwBit   = rxByte[0];
  assign txBit   = txReg[BYTE_W-1];
endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaSync,
  input  logic [3:0] devType,
  input  logic       rwBit,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  ctrlState_t       state;
  rxKind_t          kind;
  logic             readMode;
  logic             ackDrive;
  logic [CNT_W-1:0] bitCnt;

  logic devMatch, byteEnd, txEnd;
  assign devMatch = (devType == DEV_TYPE);
  assign byteEnd  = (state == ST_RX) && sclFall && (bitCnt == FULL_CNT);
  assign txEnd    = (state == ST_TX) && sclFall && (bitCnt == LAST_TX);

  always_comb begin
    strobe = '0;
    if (!startEv && !stopEv) begin
      strobe.shiftIn  = (state == ST_RX) && sclRise && (bitCnt != FULL_CNT);
      strobe.setPage  = byteEnd && (kind == K_DEV) && devMatch;
      strobe.setWord  = byteEnd && (kind == K_WORD);
      strobe.writeMem = byteEnd && (kind == K_DATA);
      strobe.incAddr  = strobe.writeMem || txEnd;
      strobe.loadTx   = sclFall && (((state == ST_ACK) && readMode) || (state == ST_MWAIT));
      strobe.shiftTx  = (state == ST_TX) && sclFall && (bitCnt != LAST_TX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_DEV;
      readMode <= 1'b0;
      ackDrive <= 1'b0;
      bitCnt   <= '0;
    end else if (startEv) begin
      state    <= ST_RX;
      kind     <= K_DEV;
      readMode <= 1'b0;
      ackDrive <= 1'b0;
      bitCnt   <= '0;
    end else if (stopEv) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt != FULL_CNT) bitCnt <= bitCnt + 1'b1;
          else if (byteEnd) begin
            if (kind != K_DEV || devMatch) begin
              state    <= ST_ACK;
              ackDrive <= 1'b1;
              if (kind == K_DEV) readMode <= rwBit;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: if (sclFall) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          if (readMode) state <= ST_TX;
          else begin
            state <= ST_RX;
            kind  <= (kind == K_DEV) ? K_WORD : K_DATA;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST_TX) state <= ST_MACK;
          else bitCnt <= bitCnt + 1'b1;
        end
        ST_MACK:  if (sclRise) state <= sdaSync ? ST_IDLE : ST_MWAIT;
        ST_MWAIT: if (sclFall) begin
          state  <= ST_TX;
          bitCnt <= '0;
        end
        default: ;
      endcase
    end
  end

  assign sdaDriveLow = ackDrive | ((state == ST_TX) & ~txBit);
endmodule

// File: rtl/twi_paged_mem.sv
module twi_paged_mem
  import twi_mem_pkg::*;
#(
  parameter int         PAGE_BITS   = 3,
  parameter int         WORD_BITS   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);
  dpStrobe_t  strobe;
  logic       startEv, stopEv, sclRise, sclFall, sdaSync, rwBit, txBit;
  logic [3:0] devType;

  twi_mem_dp #(
    .PAGE_BITS(PAGE_BITS), .WORD_BITS(WORD_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .startEv(startEv), .stopEv(stopEv), .sclRise(sclRise), .sclFall(sclFall),
    .sdaSync(sdaSync), .devType(devType), .rwBit(rwBit), .txBit(txBit)
  );

  twi_mem_ctrl #(.DEV_TYPE(DEV_TYPE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaSync(sdaSync),
    .devType(devType), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: rtl/twi_mem_chk.sv
module twi_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic sclIn,
  input logic startEv,
  input logic stopEv,
  input logic writeMem,
  input logic sdaDriveLow
);
  // R1: a start leaves the data line released
  assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    startEv |=> !sdaDriveLow);

  // R2: a stop leaves the data line released
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stopEv |=> !sdaDriveLow);

  // R4: the pull-low enable only moves while the bus clock is low
  assert_sda_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !$past(sclIn, 2));

  // R6: every stored byte is acknowledged on the next cycle
  assert_write_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    writeMem |=> sdaDriveLow);
endmodule

bind twi_paged_mem twi_mem_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .startEv(startEv),
  .stopEv(stopEv), .writeMem(strobe.writeMem), .sdaDriveLow(sdaDriveLow)
);

// File: tb/twi_paged_mem_tb.sv
`timescale 1ns/1ps
module twi_paged_mem_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  wire  sdaBus = sdaM & ~sdaDriveLow;
  int   tests = 0;
  int   fails = 0;

  always #4 clk = ~clk;

  twi_paged_mem dut_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    tick(Q);
    sclM = 1'b1; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q / 2);
    acked = (sdaBus == 1'b0);
    tick(Q / 2);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclM = 1'b1; tick(Q / 2);
      d[i] = sdaBus;
      tick(Q / 2);
      sclM = 1'b0;
    end
    tick(Q);
    sdaM = ~ackIt; tick(Q);
    sclM = 1'b1;   tick(Q);
    sclM = 1'b0;   tick(Q);
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic [2:0] page, input logic rd);
    return {4'b1010, page, rd};
  endfunction

  // set address with a write header, then repeated start and read header
  task automatic openRead(input logic [2:0] page, input logic [7:0] word, input string tag);
    bit a;
    busStart();
    sendByte(devByte(page, 1'b0), a); check(a, tag, a, 1);
    sendByte(word, a);                check(a, tag, a, 1);
    busStart();
    sendByte(devByte(page, 1'b1), a); check(a, tag, a, 1);
  endtask

  task automatic readOne(input logic [2:0] page, input logic [7:0] word,
                         input logic [7:0] exp, input string tag);
    logic [7:0] d;
    openRead(page, word, tag);
    recvByte(1'b0, d);
    check(d == exp, tag, d, exp);
    busStop();
  endtask

  task automatic testReset();
    tick(10);
    check(sdaDriveLow == 1'b0, "R2 reset release", sdaDriveLow, 0);
  endtask

  task automatic testWriteCross();
    bit a;
    logic [7:0] vals [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    busStart();
    sendByte(devByte(3'd2, 1'b0), a); check(a, "R4 ack slave address", a, 1);
    sendByte(8'hFE, a);               check(a, "R5 ack word address", a, 1);
    foreach (vals[i]) begin
      sendByte(vals[i], a);           check(a, "R6 ack data across page", a, 1);
    end
    busStop();
    tick(4);
    check(sdaDriveLow == 1'b0, "R2 release after stop", sdaDriveLow, 0);
  endtask

  task automatic testRandomRead();
    logic [7:0] d;
    openRead(3'd2, 8'hFE, "R5 random read header");
    recvByte(1'b1, d); check(d == 8'hA1, "R7 read first byte", d, 8'hA1);
    recvByte(1'b0, d); check(d == 8'hB2, "R7 read second byte", d, 8'hB2);
    for (int i = 0; i < 4; i++) begin
      tick(Q / 2);
      check(sdaDriveLow == 1'b0, "R8 released after NACK", sdaDriveLow, 0);
    end
    busStop();
  endtask

  task automatic testCurrentRead();
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(devByte(3'd3, 1'b1), a); check(a, "R7 current read header", a, 1);
    recvByte(1'b1, d); check(d == 8'hC3, "R7 current address byte", d, 8'hC3);
    recvByte(1'b0, d); check(d == 8'hD4, "R7 sequential next byte", d, 8'hD4);
    busStop();
  endtask

  task automatic testWrap();
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(devByte(3'd7, 1'b0), a); check(a, "R6 wrap header", a, 1);
    sendByte(8'hFF, a);               check(a, "R6 wrap word", a, 1);
    sendByte(8'h5A, a);               check(a, "R6 data at 7FF", a, 1);
    sendByte(8'h6B, a);               check(a, "R6 data at 000", a, 1);
    busStop();
    readOne(3'd0, 8'h00, 8'h6B, "R6 write wrapped to 000");
    openRead(3'd7, 8'hFF, "R7 wrap read header");
    recvByte(1'b1, d); check(d == 8'h5A, "R7 read at 7FF", d, 8'h5A);
    recvByte(1'b0, d); check(d == 8'h6B, "R7 read wraps to 000", d, 8'h6B);
    busStop();
  endtask

  task automatic testMismatch();
    bit a;
    busStart();
    sendByte(8'hB4, a); check(!a, "R3 wrong device type no ack", a, 0);
    sendByte(8'h00, a); check(!a, "R3 ignored word byte", a, 0);
    sendByte(8'h11, a); check(!a, "R3 ignored data byte", a, 0);
    busStop();
    readOne(3'd0, 8'h00, 8'h6B, "R3 memory untouched");
  endtask

  task automatic testStartAbort();
    bit a;
    busStart();
    sendByte(devByte(3'd1, 1'b0), a);
    sendByte(8'h20, a);
    sendByte(8'h77, a);
    sendByte(8'h88, a); check(a, "R6 preload acked", a, 1);
    busStop();
    busStart();
    sendByte(devByte(3'd1, 1'b0), a);
    sendByte(8'h20, a);
    sendByte(8'h11, a); check(a, "R1 byte before abort acked", a, 1);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStart();
    sendByte(devByte(3'd1, 1'b0), a); check(a, "R1 address rearmed after start", a, 1);
    busStop();
    readOne(3'd1, 8'h20, 8'h11, "R1 completed byte stored");
    readOne(3'd1, 8'h21, 8'h88, "R1 cut byte not stored");
  endtask

  task automatic testStopAbort();
    bit a;
    busStart();
    sendByte(devByte(3'd1, 1'b0), a);
    sendByte(8'h21, a);
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    busStop();
    tick(4);
    check(sdaDriveLow == 1'b0, "R2 stop mid-byte releases", sdaDriveLow, 0);
    sclM = 1'b0; tick(Q);
    sendByte(devByte(3'd1, 1'b0), a); check(!a, "R2 no ack without start", a, 0);
    sclM = 1'b1; tick(Q);
    readOne(3'd1, 8'h21, 8'h88, "R2 cut byte abandoned");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    testReset();
    testWriteCross();
    testRandomRead();
    testCurrentRead();
    testWrap();
    testMismatch();
    testStartAbort();
    testStopAbort();
    tick(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule